// File: doc/BRIEF.md
# Translation Lookaside Cache with Per-Page and Full Flush

This block is a small, fully associative cache of address translations that sits between a translation requester and the page table walker. Each request carries a 32-bit I/O virtual address. The cache compares the page number in bits 31:12 against every stored tag. On a hit it returns the cached physical page number and the read and write permission bits. On a miss it stalls the requester, asks the walker for that page, stores the walker's answer in the slot picked by a rotating pointer, and forwards the same answer to the requester.

Two maintenance paths remove stale entries. A per-page flush carries a full virtual address and drops only the entry whose page number matches; its page offset is ignored. A full flush drops every entry. When the walker reports a fault, the cache stops accepting requests until a fault-acknowledge pulse arrives. The acknowledge empties the cache before translation resumes, so nothing cached before the fault can be used after it.

Top module: `iotlb`

## Requirements
- R1: After reset no entry is valid, `req_ready` is 1, and `walk_req` and `resp_valid` are 0.
- R2: An accepted request whose bits 31:12 match a valid entry gives `resp_valid`=1 and `resp_hit`=1 in the next cycle, with that entry's page, read bit and write bit. Bits 11:0 of the request are ignored.
- R3: An accepted request that misses raises `walk_req` from the next cycle, with `walk_vpn` equal to the request's bits 31:12. `req_ready` is held at 0 until `walk_done`. In the cycle after `walk_done`, `resp_valid`=1 and `resp_hit`=0, and the response carries the walker's page, read bit and write bit. That result is then stored.
- R4: Fills go to slots 0,1,…,7 in turn and wrap around. This happens whether a slot is empty or not. The ninth distinct page replaces the first page filled, and leaves the second page in place.
- R5: A per-page flush (`inv_line`) removes only the entry whose tag equals bits 31:12 of `inv_iova`. All other entries keep hitting.
- R6: A full flush (`inv_all`) removes every entry.
- R7: A flush that coincides with `walk_done` and targets the page being filled leaves the new entry invalid. A full flush has the same effect. The response of that cycle still carries the walker's data.
- R8: A walk that ends with `walk_fault`=1 gives `resp_valid`=1, `resp_fault`=1 and `resp_hit`=0, and fills nothing. `req_ready` then stays 0 until `fault_done`. That acknowledge empties every entry before the next request is taken.
- R9: A `fault_done` pulse while no fault is pending has no effect on the stored entries.
- R10: A request that arrives in the same cycle as a flush that removes its entry is treated as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_iova | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Response present (one cycle) |
| resp_hit | output | 1 | Response was served from the cache |
| resp_fault | output | 1 | Walk reported a fault |
| resp_page | output | 20 | Physical page number |
| resp_rd | output | 1 | Read permitted |
| resp_wr | output | 1 | Write permitted |
| walk_req | output | 1 | Walk requested (level, held until done) |
| walk_vpn | output | 20 | Page number to walk |
| walk_done | input | 1 | Walker result present |
| walk_fault | input | 1 | Walker found no valid mapping |
| walk_page | input | 20 | Walker's physical page number |
| walk_rd | input | 1 | Walker's read permission |
| walk_wr | input | 1 | Walker's write permission |
| inv_line | input | 1 | Flush the entry matching `inv_iova` |
| inv_iova | input | 32 | Address selecting the entry to flush |
| inv_all | input | 1 | Flush every entry |
| fault_done | input | 1 | Fault acknowledged, resume translation |

## Verification
The properties assume that the walker pulses `walk_done` only while `walk_req` is high, and that a requester held off by a low `req_ready` keeps its address steady. The stimulus raises `walk_done` only after it has seen `walk_req` at a falling edge. It presents each request only once `req_ready` is high, so no request is ever pending across a stall. Flush and acknowledge pulses are placed deliberately at the accept cycle, at the fill cycle, in the idle state and in the fault state, to exercise each ordering the requirements describe.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WALK  = 2'd1,
    ST_FAULT = 2'd2
  } tlb_state_e;
endpackage

// File: rtl/iotlb_cam.sv
// Tag store, match, kill and fill for all entries.
module iotlb_cam #(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [VPN_W-1:0]       look_vpn,
  input  logic                   inv_line,
  input  logic [VPN_W-1:0]       inv_vpn,
  input  logic                   inv_all,
  input  logic                   clr_all,
  input  logic                   fill_en,
  input  logic [IDX_W-1:0]       fill_idx,
  input  logic [VPN_W-1:0]       fill_vpn,
  input  logic [PPN_W-1:0]       fill_ppn,
  input  logic                   fill_rd,
  input  logic                   fill_wr,
  output logic [NUM_ENTRIES-1:0] hit_vec,
  output logic [PPN_W-1:0]       hit_ppn,
  output logic                   hit_rd,
  output logic                   hit_wr
);
  logic [VPN_W-1:0]       tag_q [NUM_ENTRIES];
  logic [PPN_W-1:0]       ppn_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] rd_q, wr_q;
  logic [NUM_ENTRIES-1:0] vld_q, vld_d, kill;
  logic                   fill_kill;

  // a flush aimed at the page being filled beats the fill
  assign fill_kill = inv_all | clr_all | (inv_line & (inv_vpn == fill_vpn));

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic we;
    assign we         = fill_en & (fill_idx == IDX_W'(g));
    assign kill[g]    = inv_all | clr_all | (inv_line & (tag_q[g] == inv_vpn));
    assign hit_vec[g] = vld_q[g] & ~kill[g] & (tag_q[g] == look_vpn);
    assign vld_d[g]   = we ? ~fill_kill : (vld_q[g] & ~kill[g]);

    always_ff @(posedge clk) begin
      if (we) begin
        tag_q[g] <= fill_vpn;
        ppn_q[g] <= fill_ppn;
        rd_q[g]  <= fill_rd;
        wr_q[g]  <= fill_wr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_comb begin
    hit_ppn = '0;
    hit_rd  = 1'b0;
    hit_wr  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_ppn = hit_ppn | ppn_q[i];
        hit_rd  = hit_rd | rd_q[i];
        hit_wr  = hit_wr | wr_q[i];
      end
    end
  end
endmodule

// File: rtl/iotlb_victim.sv
// Rotating fill pointer.
module iotlb_victim #(
  parameter int NUM_ENTRIES = 8,
  parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) ptr_d = (ptr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;
endmodule

// File: rtl/iotlb_ctrl.sv
// Request, walk and fault sequencing plus the response register.
module iotlb_ctrl
  import iotlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 20,
  parameter int PPN_W       = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VPN_W-1:0]       req_vpn,
  output logic                   req_ready,
  input  logic [NUM_ENTRIES-1:0] hit_vec,
  input  logic [PPN_W-1:0]       hit_ppn,
  input  logic                   hit_rd,
  input  logic                   hit_wr,
  output logic                   walk_req,
  output logic [VPN_W-1:0]       walk_vpn,
  input  logic                   walk_done,
  input  logic                   walk_fault,
  input  logic [PPN_W-1:0]       walk_page,
  input  logic                   walk_rd,
  input  logic                   walk_wr,
  input  logic                   fault_done,
  output logic                   fill_en,
  output logic                   clr_all,
  output logic                   resp_valid,
  output logic                   resp_hit,
  output logic                   resp_fault,
  output logic [PPN_W-1:0]       resp_page,
  output logic                   resp_rd,
  output logic                   resp_wr
);
  tlb_state_e       state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic             accept, hit;
  logic             rv_q, rv_d, ld, rh_d, rf_d, rr_d, rw_d;
  logic             rh_q, rf_q, rr_q, rw_q;
  logic [PPN_W-1:0] rp_d, rp_q;

  assign hit    = |hit_vec;
  assign accept = req_valid & (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    rv_d    = 1'b0;
    ld      = 1'b0;
    rh_d    = 1'b0;
    rf_d    = 1'b0;
    rp_d    = walk_page;
    rr_d    = walk_rd;
    rw_d    = walk_wr;
    fill_en = 1'b0;
    clr_all = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (hit) begin
            rv_d = 1'b1;
            ld   = 1'b1;
            rh_d = 1'b1;
            rp_d = hit_ppn;
            rr_d = hit_rd;
            rw_d = hit_wr;
          end else begin
            state_d = ST_WALK;
          end
        end
      end
      ST_WALK: begin
        if (walk_done) begin
          rv_d = 1'b1;
          ld   = 1'b1;
          if (walk_fault) begin
            rf_d    = 1'b1;
            state_d = ST_FAULT;
          end else begin
            fill_en = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_FAULT: begin
        if (fault_done) begin
          clr_all = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rv_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      rv_q    <= rv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) vpn_q <= req_vpn;
    if (ld) begin
      rh_q <= rh_d;
      rf_q <= rf_d;
      rp_q <= rp_d;
      rr_q <= rr_d;
      rw_q <= rw_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign walk_req   = (state_q == ST_WALK);
  assign walk_vpn   = vpn_q;
  assign resp_valid = rv_q;
  assign resp_hit   = rh_q;
  assign resp_fault = rf_q;
  assign resp_page  = rp_q;
  assign resp_rd    = rr_q;
  assign resp_wr    = rw_q;
endmodule

// File: rtl/iotlb.sv
module iotlb #(
  parameter int NUM_ENTRIES = 8,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32,
  parameter int PAGE_BITS   = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [VA_W-1:0]           req_iova,
  output logic                      resp_valid,
  output logic                      resp_hit,
  output logic                      resp_fault,
  output logic [PA_W-PAGE_BITS-1:0] resp_page,
  output logic                      resp_rd,
  output logic                      resp_wr,
  output logic                      walk_req,
  output logic [VA_W-PAGE_BITS-1:0] walk_vpn,
  input  logic                      walk_done,
  input  logic                      walk_fault,
  input  logic [PA_W-PAGE_BITS-1:0] walk_page,
  input  logic                      walk_rd,
  input  logic                      walk_wr,
  input  logic                      inv_line,
  input  logic [VA_W-1:0]           inv_iova,
  input  logic                      inv_all,
  input  logic                      fault_done
);
  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PPN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = $clog2(NUM_ENTRIES);

  logic [NUM_ENTRIES-1:0] hit_vec;
  logic [PPN_W-1:0]       hit_ppn;
  logic                   hit_rd, hit_wr, fill_en, clr_all;
  logic [IDX_W-1:0]       fill_idx;
  logic                   unused_offset_bits;

  assign unused_offset_bits = ^{req_iova[PAGE_BITS-1:0], inv_iova[PAGE_BITS-1:0]};

  iotlb_cam #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)) u_cam (
    .clk(clk), .rst_n(rst_n),
    .look_vpn(req_iova[VA_W-1:PAGE_BITS]),
    .inv_line(inv_line), .inv_vpn(inv_iova[VA_W-1:PAGE_BITS]),
    .inv_all(inv_all), .clr_all(clr_all),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(walk_vpn),
    .fill_ppn(walk_page), .fill_rd(walk_rd), .fill_wr(walk_wr),
    .hit_vec(hit_vec), .hit_ppn(hit_ppn), .hit_rd(hit_rd), .hit_wr(hit_wr)
  );

  iotlb_victim #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(fill_en), .ptr(fill_idx)
  );

  iotlb_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vpn(req_iova[VA_W-1:PAGE_BITS]), .req_ready(req_ready),
    .hit_vec(hit_vec), .hit_ppn(hit_ppn), .hit_rd(hit_rd), .hit_wr(hit_wr),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_done(walk_done),
    .walk_fault(walk_fault), .walk_page(walk_page), .walk_rd(walk_rd), .walk_wr(walk_wr),
    .fault_done(fault_done), .fill_en(fill_en), .clr_all(clr_all),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_page(resp_page), .resp_rd(resp_rd), .resp_wr(resp_wr)
  );
endmodule

// File: rtl/iotlb_chk.sv
module iotlb_chk #(
  parameter int NUM_ENTRIES = 8,
  parameter int VPN_W       = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   walk_req,
  input logic [VPN_W-1:0]       walk_vpn,
  input logic                   walk_done,
  input logic                   walk_fault,
  input logic                   resp_valid,
  input logic                   resp_hit,
  input logic                   resp_fault,
  input logic [NUM_ENTRIES-1:0] hit_vec,
  input logic                   fill_en
);
  // R2
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R3
  accept_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> (resp_valid && resp_hit) || walk_req);

  // R3
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && !walk_done |=> walk_req && $stable(walk_vpn));

  // R3
  walk_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && walk_done |=> resp_valid && !resp_hit && !walk_req);

  // R8
  fault_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault |-> !req_ready && !resp_hit);

  // R7
  fill_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> walk_req && walk_done && !walk_fault);
endmodule

bind iotlb iotlb_chk #(.NUM_ENTRIES(NUM_ENTRIES), .VPN_W(VPN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_done(walk_done),
  .walk_fault(walk_fault), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_fault(resp_fault), .hit_vec(hit_vec), .fill_en(fill_en)
);

// File: tb/iotlb_test.sv
module iotlb_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_iova = '0;
  logic        walk_done = 1'b0, walk_fault = 1'b0, walk_rd = 1'b0, walk_wr = 1'b0;
  logic [19:0] walk_page = '0;
  logic        inv_line = 1'b0, inv_all = 1'b0, fault_done = 1'b0;
  logic [31:0] inv_iova = '0;
  logic        req_ready, resp_valid, resp_hit, resp_fault, resp_rd, resp_wr, walk_req;
  logic [19:0] resp_page, walk_vpn;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  string cur_tag = "R1";

  always #4ns clk = ~clk;

  iotlb uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_iova(req_iova), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_fault(resp_fault), .resp_page(resp_page), .resp_rd(resp_rd),
    .resp_wr(resp_wr), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .walk_done(walk_done), .walk_fault(walk_fault), .walk_page(walk_page),
    .walk_rd(walk_rd), .walk_wr(walk_wr), .inv_line(inv_line),
    .inv_iova(inv_iova), .inv_all(inv_all), .fault_done(fault_done)
  );

  // ---------------- reference model ----------------
  logic [19:0] m_tag [N];
  logic [19:0] m_page [N];
  bit          m_rdb [N];
  bit          m_wrb [N];
  bit          m_v [N];
  bit          kill [N];
  int          m_state, m_ptr, hi, fs;
  bit          filled;
  logic [19:0] m_wvpn, rvpn, ivpn;
  bit          m_rv, m_rh, m_rf, m_rr, m_rw;
  logic [19:0] m_rp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_ptr = 0; m_rv = 0; m_wvpn = '0;
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_tag[i] = '0; end
    end else begin
      rvpn = req_iova[31:12];
      ivpn = inv_iova[31:12];
      filled = 0;
      fs = m_ptr;
      for (int i = 0; i < N; i++)
        kill[i] = inv_all || (inv_line && m_tag[i] == ivpn) || (m_state == 2 && fault_done);
      m_rv = 0;
      case (m_state)
        0: if (req_valid) begin
          hi = -1;
          for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == rvpn && !kill[i]) hi = i;
          if (hi >= 0) begin
            m_rv = 1; m_rh = 1; m_rf = 0;
            m_rp = m_page[hi]; m_rr = m_rdb[hi]; m_rw = m_wrb[hi];
          end else begin
            m_state = 1; m_wvpn = rvpn;
          end
        end
        1: if (walk_done) begin
          m_rv = 1; m_rh = 0; m_rf = walk_fault;
          m_rp = walk_page; m_rr = walk_rd; m_rw = walk_wr;
          if (walk_fault) m_state = 2;
          else begin filled = 1; m_state = 0; end
        end
        default: if (fault_done) m_state = 0;
      endcase
      for (int i = 0; i < N; i++) if (kill[i]) m_v[i] = 0;
      if (filled) begin
        m_tag[fs] = m_wvpn; m_page[fs] = walk_page;
        m_rdb[fs] = walk_rd; m_wrb[fs] = walk_wr;
        m_v[fs] = !(inv_all || (inv_line && ivpn == m_wvpn));
        m_ptr = (m_ptr + 1) % N;
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit bad;
      bad = 0;
      n_checks++;
      if (req_ready !== (m_state == 0)) begin
        bad = 1; $display("FAIL %s model req_ready: actual %0b expected %0b", cur_tag, req_ready, m_state == 0);
      end
      if (walk_req !== (m_state == 1)) begin
        bad = 1; $display("FAIL %s model walk_req: actual %0b expected %0b", cur_tag, walk_req, m_state == 1);
      end
      if (m_state == 1 && walk_vpn !== m_wvpn) begin
        bad = 1; $display("FAIL %s model walk_vpn: actual %0h expected %0h", cur_tag, walk_vpn, m_wvpn);
      end
      if (resp_valid !== m_rv) begin
        bad = 1; $display("FAIL %s model resp_valid: actual %0b expected %0b", cur_tag, resp_valid, m_rv);
      end else if (m_rv) begin
        if (resp_hit !== m_rh || resp_fault !== m_rf) begin
          bad = 1; $display("FAIL %s model hit/fault: actual %0b%0b expected %0b%0b",
                            cur_tag, resp_hit, resp_fault, m_rh, m_rf);
        end
        if (!m_rf && {resp_page, resp_rd, resp_wr} !== {m_rp, m_rr, m_rw}) begin
          bad = 1; $display("FAIL %s model data: actual %0h expected %0h",
                            cur_tag, {resp_page, resp_rd, resp_wr}, {m_rp, m_rr, m_rw});
        end
      end
      if (bad) n_fail++;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] iov(input int i, input logic [11:0] off);
    logic [19:0] v;
    v = 20'h00400 + 20'(i) * 20'h01001;
    return {v, off};
  endfunction

  function automatic logic [19:0] pg(input int i);
    return 20'h80000 + 20'(i) * 20'h00111;
  endfunction

  // co: 0 none, 1 page flush at walk_done, 2 full flush at walk_done, 3 page flush at accept
  task automatic access(input logic [31:0] a, input logic [19:0] page, input logic rd, input logic wr,
                        input logic flt, input int dly, input logic exp_hit, input int co, input string tag);
    cur_tag = tag;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_iova = a;
    if (co == 3) begin inv_line = 1'b1; inv_iova = a; end
    @(negedge clk);
    req_valid = 1'b0; inv_line = 1'b0;
    if (walk_req) begin
      repeat (dly) @(negedge clk);
      walk_done = 1'b1; walk_page = page; walk_rd = rd; walk_wr = wr; walk_fault = flt;
      if (co == 1) begin inv_line = 1'b1; inv_iova = a ^ 32'h5A5; end
      if (co == 2) inv_all = 1'b1;
      @(negedge clk);
      walk_done = 1'b0; walk_fault = 1'b0; inv_line = 1'b0; inv_all = 1'b0;
    end
    chk(tag, "resp_valid", 32'(resp_valid), 32'd1);
    chk(tag, "resp_hit", 32'(resp_hit), 32'(exp_hit));
    chk(tag, "resp_fault", 32'(resp_fault), 32'(flt));
    if (!flt) chk(tag, "resp data", {10'd0, resp_page, resp_rd, resp_wr}, {10'd0, page, rd, wr});
  endtask

  task automatic acc(input int i, input logic [11:0] off, input logic exp_hit, input string tag);
    access(iov(i, off), pg(i), 1'(i % 2), 1'((i / 2) % 2), 1'b0, i % 3, exp_hit, 0, tag);
  endtask

  task automatic pulse_line(input logic [31:0] a);
    inv_line = 1'b1; inv_iova = a; @(negedge clk); inv_line = 1'b0;
  endtask

  task automatic pulse_all();
    inv_all = 1'b1; @(negedge clk); inv_all = 1'b0;
  endtask

  task automatic pulse_fdone();
    fault_done = 1'b1; @(negedge clk); fault_done = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "walk_req", 32'(walk_req), 32'd0);
    chk("R1", "resp_valid", 32'(resp_valid), 32'd0);

    acc(0, 12'h000, 1'b0, "R3");
    acc(0, 12'hABC, 1'b1, "R2");
    for (int i = 1; i < 8; i++) acc(i, 12'h000, 1'b0, "R3");
    for (int i = 0; i < 8; i++) acc(i, 12'h123, 1'b1, "R2");

    acc(8, 12'h000, 1'b0, "R4");
    acc(1, 12'h000, 1'b1, "R4");
    acc(0, 12'h000, 1'b0, "R4");

    cur_tag = "R5";
    pulse_line(iov(3, 12'hFFF));
    acc(4, 12'h000, 1'b1, "R5");
    acc(3, 12'h000, 1'b0, "R5");

    access(iov(5, 12'h010), pg(5), 1'b1, 1'b0, 1'b0, 1, 1'b0, 3, "R10");
    acc(5, 12'h000, 1'b1, "R10");

    access(iov(9, 12'h000), pg(9), 1'b1, 1'b1, 1'b0, 2, 1'b0, 1, "R7");
    acc(9, 12'h000, 1'b0, "R7");
    access(iov(10, 12'h000), pg(10), 1'b0, 1'b0, 1'b0, 0, 1'b0, 2, "R7");
    acc(9, 12'h000, 1'b0, "R6");
    acc(10, 12'h000, 1'b0, "R7");

    cur_tag = "R6";
    pulse_all();
    acc(10, 12'h000, 1'b0, "R6");

    cur_tag = "R9";
    pulse_fdone();
    acc(10, 12'h000, 1'b1, "R9");

    access(iov(11, 12'h000), pg(11), 1'b1, 1'b1, 1'b1, 1, 1'b0, 0, "R8");
    @(negedge clk);
    chk("R8", "req_ready stalled", 32'(req_ready), 32'd0);
    chk("R8", "walk_req idle", 32'(walk_req), 32'd0);
    @(negedge clk);
    chk("R8", "req_ready still stalled", 32'(req_ready), 32'd0);
    pulse_fdone();
    chk("R8", "req_ready resumed", 32'(req_ready), 32'd1);
    acc(10, 12'h000, 1'b0, "R8");
    acc(11, 12'h000, 1'b0, "R8");
    acc(11, 12'h777, 1'b1, "R8");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule